// File: doc/BRIEF.md
# Programmable Burst Cycle Timing Sequencer

This block paces bus cycles between a processor-side request port and a line-organised memory data port, such as a secondary cache or a page-mode array. A request either moves one 32-bit word or moves a four-word burst covering an aligned 16-byte line. Before the first word of a burst the sequencer waits a selectable leadoff count of clocks. Before every later word it waits a separately selectable trailing count. Reads and writes have their own timing tables, so a write burst can run slower than a read burst.

The block computes the addresses of the three words that follow the first. It starts at the requested word and steps upward through the line, wrapping back to word zero after word three. A one-clock ready strobe marks the clock on which each word completes. A done pulse marks the end of the whole transfer. While a transfer is running, a busy output holds off new requests. The timing selection is captured only when a request is accepted.

Top module: `burst_seq`

## Requirements
- R1: While reset is held, and on the first clock after it is released, `busy_o`, `mem_stb_o`, `rdy_o`, `done_o` and `mem_we_o` are all low.
- R2: A single transfer (`burst_i`=0) always lasts two clocks, whatever `prof_i` holds. `mem_stb_o` is high in the first clock after acceptance. `rdy_o` and `done_o` are high together in the second clock.
- R3: A burst moves four words. `mem_stb_o` is high only in the first clock of the transfer. The following three words have no strobe clock of their own.
- R4: For reads, `prof_i` bit 0 sets the leadoff count: 0 selects 2 clocks and 1 selects 3. Bit 1 sets the trailing count per word: 0 selects 1 clock and 1 selects 2. The four codes 00, 01, 10 and 11 therefore give 2-1-1-1, 3-1-1-1, 2-2-2-2 and 3-2-2-2.
- R5: For writes, the leadoff count is 3 clocks when `prof_i` bit 0 is 0 and 4 clocks when it is 1. The trailing count is set by bit 1 as in R4. Code 01 therefore gives 4-1-1-1.
- R6: A read burst with code 00 finishes in 5 clocks. Four back-to-back single transfers take 8 clocks from the first strobe to the last done.
- R7: `mem_addr_o` bits [1:0] are zero. Bits above 3 equal the request address for the whole transfer. Bits [3:2] start at the request's bits [3:2] and increase by one, modulo 4, after every word but the last.
- R8: `rdy_o` is high for exactly one clock, and that clock is the final clock of each word. `done_o` is high only together with the last word's `rdy_o`.
- R9: `prof_i`, `we_i` and `burst_i` are sampled only on the clock edge that accepts a request. Changes to them during a transfer do not alter that transfer.
- R10: `busy_o` is high from the first clock of a transfer up to, but not including, its done clock. A request made while `busy_o` is high is ignored. A request made in the done clock is accepted, and its strobe appears on the next clock.
- R11: `mem_we_o` equals the accepted `we_i` for every clock of the transfer and is low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe |
| addr_i | input | AW | Start byte address |
| we_i | input | 1 | 1 = write, 0 = read |
| burst_i | input | 1 | 1 = four-word burst, 0 = single word |
| prof_i | input | 2 | Timing code (bit 0 leadoff, bit 1 trailing) |
| busy_o | output | 1 | Transfer in progress; requests are held off |
| mem_addr_o | output | AW | Word address of the current beat |
| mem_stb_o | output | 1 | Address strobe, first clock of a transfer |
| mem_we_o | output | 1 | Write direction of the running transfer |
| rdy_o | output | 1 | Beat complete strobe |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The bench builds the block with a 16-bit address and the default counting bases (read leadoff 2, write leadoff 3, trailing 1, single 2 clocks). With these values every timing code, both directions, both transfer sizes and all four starting words can be swept in full: 64 transfers, each compared clock by clock. During each sweep transfer the bench drives stray requests with inverted fields while the block is busy, which tests that those requests are ignored and that the fields are sampled only at acceptance. Back-to-back single transfers and the fastest burst are then timed to test the 8-clock versus 5-clock comparison and acceptance in the done clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    parameter int unsigned CNT_W = 3;

    typedef struct packed {
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] trail;
    } timing_t;
endpackage

// File: rtl/burst_prof_dec.sv
module burst_prof_dec
    import burst_seq_pkg::*;
#(
    parameter int unsigned RD_LEAD_BASE = 2,
    parameter int unsigned WR_LEAD_BASE = 3,
    parameter int unsigned TRAIL_BASE   = 1
) (
    input  logic       we,
    input  logic [1:0] code,
    output timing_t    tim
);
    localparam logic [CNT_W-1:0] RD_L = CNT_W'(RD_LEAD_BASE);
    localparam logic [CNT_W-1:0] WR_L = CNT_W'(WR_LEAD_BASE);
    localparam logic [CNT_W-1:0] TR_B = CNT_W'(TRAIL_BASE);

    always_comb begin
        tim.lead  = (we ? WR_L : RD_L) + {{(CNT_W-1){1'b0}}, code[0]};
        tim.trail = TR_B + {{(CNT_W-1){1'b0}}, code[1]};
    end
endmodule

// File: rtl/burst_seq_ctl.sv
module burst_seq_ctl
    import burst_seq_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned SINGLE_CLKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic          burst,
    input  timing_t       tim,
    output logic          busy,
    output logic          stb,
    output logic          rdy,
    output logic          done,
    output logic          we_out,
    output logic [AW-5:0] line,
    output logic [1:0]    word
);
    localparam logic [CNT_W-1:0] SGL = CNT_W'(SINGLE_CLKS);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             act;
        logic             we;
        logic             bst;
        logic             first;
        logic [1:0]       word;
        logic [1:0]       beat;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] trail;
        logic [AW-5:0]    line;
    } state_t;

    state_t s_q, s_d;
    logic   last, accept;

    always_comb begin
        last   = s_q.bst ? (s_q.beat == 2'd3) : 1'b1;
        rdy    = s_q.act && (s_q.cnt == ONE);
        done   = rdy && last;
        busy   = s_q.act && !done;
        accept = req && !busy;
        stb    = s_q.act && s_q.first;
        we_out = s_q.act && s_q.we;
        line   = s_q.line;
        word   = s_q.word;

        s_d = s_q;
        if (s_q.act) begin
            s_d.first = 1'b0;
            if (rdy) begin
                if (last) begin
                    s_d.act = 1'b0;
                end else begin
                    s_d.beat = s_q.beat + 2'd1;
                    s_d.word = s_q.word + 2'd1;
                    s_d.cnt  = s_q.trail;
                end
            end else begin
                s_d.cnt = s_q.cnt - ONE;
            end
        end
        if (accept) begin
            s_d.act   = 1'b1;
            s_d.we    = we;
            s_d.bst   = burst;
            s_d.first = 1'b1;
            s_d.word  = addr[3:2];
            s_d.beat  = 2'd0;
            s_d.cnt   = burst ? tim.lead : SGL;
            s_d.trail = tim.trail;
            s_d.line  = addr[AW-1:4];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-5:0] line,
    input  logic [1:0]    word,
    output logic [AW-1:0] addr
);
    always_comb addr = {line, word, 2'b00};
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned AW           = 32,
    parameter int unsigned RD_LEAD_BASE = 2,
    parameter int unsigned WR_LEAD_BASE = 3,
    parameter int unsigned TRAIL_BASE   = 1,
    parameter int unsigned SINGLE_CLKS  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic          burst_i,
    input  logic [1:0]    prof_i,
    output logic          busy_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_stb_o,
    output logic          mem_we_o,
    output logic          rdy_o,
    output logic          done_o
);
    timing_t       tim;
    logic [AW-5:0] line;
    logic [1:0]    word;

    burst_prof_dec #(
        .RD_LEAD_BASE(RD_LEAD_BASE),
        .WR_LEAD_BASE(WR_LEAD_BASE),
        .TRAIL_BASE  (TRAIL_BASE)
    ) u_dec (
        .we  (we_i),
        .code(prof_i),
        .tim (tim)
    );

    burst_seq_ctl #(
        .AW         (AW),
        .SINGLE_CLKS(SINGLE_CLKS)
    ) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_i),
        .addr  (addr_i),
        .we    (we_i),
        .burst (burst_i),
        .tim   (tim),
        .busy  (busy_o),
        .stb   (mem_stb_o),
        .rdy   (rdy_o),
        .done  (done_o),
        .we_out(mem_we_o),
        .line  (line),
        .word  (word)
    );

    burst_addr_gen #(.AW(AW)) u_agen (
        .line(line),
        .word(word),
        .addr(mem_addr_o)
    );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_stb_o,
    input logic          mem_we_o,
    input logic          rdy_o,
    input logic          done_o
);
    logic [1:0] prev_word;
    logic [1:0] step;

    always_ff @(posedge clk) prev_word <= mem_addr_o[3:2];
    assign step = mem_addr_o[3:2] - prev_word;

    p_done_with_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> rdy_o);

    p_stb_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stb_o |=> !mem_stb_o);

    p_stb_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stb_o |-> (busy_o && !rdy_o));

    p_word_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && !done_o) |=> (step == 2'd1 && $stable(mem_addr_o[AW-1:4])));

    p_busy_midway_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && !done_o) |-> busy_o);

    p_we_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_stb_o) |-> $stable(mem_we_o));
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .mem_addr_o(mem_addr_o),
    .mem_stb_o (mem_stb_o),
    .mem_we_o  (mem_we_o),
    .rdy_o     (rdy_o),
    .done_o    (done_o)
);

// File: tb/burst_seq_test.sv
module burst_seq_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          we_i = 1'b0;
    logic          burst_i = 1'b0;
    logic [1:0]    prof_i = 2'd0;
    logic          busy_o, mem_stb_o, mem_we_o, rdy_o, done_o;
    logic [AW-1:0] mem_addr_o;

    int checks = 0;
    int errors = 0;

    burst_seq #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
        .we_i(we_i), .burst_i(burst_i), .prof_i(prof_i),
        .busy_o(busy_o), .mem_addr_o(mem_addr_o), .mem_stb_o(mem_stb_o),
        .mem_we_o(mem_we_o), .rdy_o(rdy_o), .done_o(done_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(!busy_o && !mem_stb_o && !rdy_o && !done_o && !mem_we_o, tag,
            {busy_o, mem_stb_o, rdy_o, done_o, mem_we_o}, 0);
    endtask

    // One transfer, swept: stray requests with inverted fields while busy (R9, R10)
    task automatic run_txn(input bit we, input bit bst, input logic [1:0] pf, input logic [AW-1:0] a);
        int lead, trail, total, beat, ends;
        logic [AW-1:0] exp_a;
        lead  = bst ? ((we ? 3 : 2) + int'(pf[0])) : 2;
        trail = bst ? (1 + int'(pf[1])) : 0;
        total = bst ? lead + 3 * trail : 2;
        @(negedge clk);
        chk_idle("R10 idle before request");
        req_i = 1'b1; addr_i = a; we_i = we; burst_i = bst; prof_i = pf;
        beat = 0; ends = lead;
        for (int c = 1; c <= total; c++) begin
            @(negedge clk);
            exp_a = {a[AW-1:4], a[3:2] + 2'(beat), 2'b00};
            chk(mem_stb_o == (c == 1), bst ? "R3 strobe" : "R2 strobe", mem_stb_o, (c == 1));
            chk(rdy_o == (c == ends), we ? "R5 ready timing" : "R4 ready timing", rdy_o, (c == ends));
            chk(done_o == (c == total), "R8 done timing", done_o, (c == total));
            chk(busy_o == (c != total), "R10 busy", busy_o, (c != total));
            chk(mem_addr_o == exp_a, "R7 beat address", mem_addr_o, exp_a);
            chk(mem_we_o == we, "R11 write flag", mem_we_o, we);
            if (c == ends) begin
                beat++;
                ends += trail;
            end
            req_i = (c != total); addr_i = ~a; we_i = ~we; burst_i = ~bst; prof_i = ~pf;
        end
        @(negedge clk);
        chk_idle("R10 stray requests ignored");
        req_i = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int first_stb, last_done, cyc;
        repeat (3) @(negedge clk);
        chk_idle("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");

        for (int w = 0; w < 2; w++)
            for (int b = 0; b < 2; b++)
                for (int p = 0; p < 4; p++)
                    for (int s = 0; s < 4; s++)
                        run_txn(w[0], b[0], p[1:0], AW'(16'h5A30 + s * 4 + p * 16'h0100));

        // Four back-to-back singles, new request in each done clock (R6, R10)
        @(negedge clk);
        first_stb = -1; last_done = -1; cyc = 0;
        req_i = 1'b1; burst_i = 1'b0; we_i = 1'b0; prof_i = 2'd3; addr_i = 16'h1000;
        for (int n = 0; n < 4; ) begin
            @(negedge clk);
            cyc++;
            if (mem_stb_o && first_stb < 0) first_stb = cyc;
            if (done_o) begin
                n++;
                last_done = cyc;
                req_i = (n < 4);
                addr_i = addr_i + 16'd4;
            end
        end
        chk(last_done - first_stb + 1 == 8, "R6 four singles clocks", last_done - first_stb + 1, 8);
        @(negedge clk);
        chk_idle("R2 idle after singles");

        // Fastest read burst (R6)
        req_i = 1'b1; burst_i = 1'b1; prof_i = 2'd0; addr_i = 16'h2008; we_i = 1'b0;
        cyc = 0; first_stb = -1; last_done = -1;
        while (last_done < 0) begin
            @(negedge clk);
            req_i = 1'b0;
            cyc++;
            if (mem_stb_o && first_stb < 0) first_stb = cyc;
            if (done_o) last_done = cyc;
        end
        chk(last_done - first_stb + 1 == 5, "R6 fastest burst clocks", last_done - first_stb + 1, 5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule